// File: doc/BRIEF.md
# Parallel Handshake Port Controller

This block is the register-mapped core of a 16-bit parallel port that moves data to and from a peripheral under handshake control. An 8-bit host bus reaches it through a 4-bit address offset. Some host accesses have side effects as well as moving data. Writing an output byte turns the direction line toward output. Reading an input byte releases that line. A dedicated read starts an input handshake. A dedicated write starts an output handshake: it raises the handshake strobe after a programmable number of clock cycles.

The peripheral answers on a ready flag. When the flag goes from ready to busy, the block drops the strobe. When the flag goes from busy to ready, the block latches the 16 input data lines. A host write to the reset offset starts a timed, active-low peripheral reset pulse. Static configuration inputs set the output data polarity, the level that counts as a healthy status line, and whether an interface reset also clears the output data.

Top module: `hsp_ctrl`

## Requirements
- R1: After the block reset, the strobe is low, the direction line is high (released), the peripheral reset line is high, the auxiliary drives are 0 and the data outputs are all zero with polarity inversion off.
- R2: A write of any data to offset 1 drives the peripheral reset line low for exactly RST_CYC cycles. It clears the strobe and cancels a pending delayed strobe. It clears the output data latch only when the clear-enable input is high.
- R3: A write to offset 8 loads data lines 7:0 and a write to offset 9 loads data lines 15:8. Each such write drives the direction line low. The data outputs show the latch XOR the inversion input on every bit.
- R4: A write to offset 10 loads lines 15:8 and drives the direction line low. The strobe then rises exactly DLY_CYC cycles after that write's clock edge. A new offset-10 write restarts the count.
- R5: A read of offset 8 returns input byte 7:0 and a read of offset 9 returns input byte 15:8. Both reads set the direction line high.
- R6: A read of offset 10 sets the direction line high and sets the strobe on the same clock edge.
- R7: A write of any data to offset 0 sets the strobe. A ready-to-busy transition of the ready flag clears it, unless a set request arrives in the same cycle.
- R8: A read of offset 0 returns 1 when the strobe is low and the ready flag is high, and 0 otherwise. A read of offset 1 always returns 3. Unmapped offsets read 0.
- R9: A write to offset 7 drives auxiliary output bit n when data bit n is 1, for n in 0 and 1. A read of offset 7 returns 0 in bits 7:4. Bit 0 is status input 0 being low, bit 1 is status input 1 being low, bit 2 is the attention input being low, and bit 3 is the health input equal to the configured healthy level.
- R10: The 16 input lines are latched on a busy-to-ready transition of the ready flag. Later changes on those lines do not alter the bytes returned by reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low block reset |
| host_addr_i | input | 4 | Register offset |
| host_wr_i | input | 1 | Host write strobe, one cycle per access |
| host_rd_i | input | 1 | Host read strobe, one cycle per access |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for the current offset |
| dout_o | output | 16 | Output data lines |
| din_i | input | 16 | Input data lines |
| strb_o | output | 1 | Handshake strobe to the peripheral |
| dir_o | output | 1 | Direction line, 0 while outputting, 1 when released |
| prst_n_o | output | 1 | Active-low peripheral reset pulse |
| aux_lo_o | output | 2 | Auxiliary drive enables, 1 pulls the line low |
| flag_rdy_i | input | 1 | Peripheral ready flag, 1 means ready |
| stat_in_i | input | 2 | General status lines |
| attn_n_i | input | 1 | Active-low attention line |
| health_i | input | 1 | Peripheral health line |
| health_ok_lvl_i | input | 1 | Level of health_i that means healthy |
| dout_inv_i | input | 1 | Invert output data polarity |
| dout_clr_en_i | input | 1 | Interface reset also clears output data |

## Verification
The handshake is driven three ways: by the direct strobe write, by the input-start read, and by the delayed output write. Each is followed by ready-to-busy and busy-to-ready flag edges. These runs show which edge clears the strobe and which one captures data. The delayed strobe is sampled one cycle before its due edge and on that edge, both after a single write and after a restart. This catches a count that is off by one or that is not reloaded. Interface reset is applied with the clear option low and then high, and also while a delayed strobe is pending. Data is written with both polarity settings, so inversion, selective clearing and cancellation are each seen at the outputs.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int PORT_W = 16;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 4;

  localparam logic [OFF_W-1:0] OFF_STRB  = 4'd0;
  localparam logic [OFF_W-1:0] OFF_RESET = 4'd1;
  localparam logic [OFF_W-1:0] OFF_AUX   = 4'd7;
  localparam logic [OFF_W-1:0] OFF_LO    = 4'd8;
  localparam logic [OFF_W-1:0] OFF_HI    = 4'd9;
  localparam logic [OFF_W-1:0] OFF_HI_DS = 4'd10;

  localparam logic [BYTE_W-1:0] PORT_ID = 8'd3;

  // Interface-ready value: strobe idle and peripheral ready.
  function automatic logic fn_ready(input logic strb, input logic rdy);
    return !strb && rdy;
  endfunction

  // Status byte: every line reported as "asserted" (low-true or healthy).
  function automatic logic [BYTE_W-1:0] fn_stat(input logic [1:0] stat,
                                                input logic attn_n,
                                                input logic health,
                                                input logic ok_lvl);
    return {4'b0000, (health == ok_lvl), !attn_n, !stat[1], !stat[0]};
  endfunction

  // Data line drive with selectable polarity.
  function automatic logic [PORT_W-1:0] fn_drive(input logic [PORT_W-1:0] q,
                                                 input logic inv);
    return q ^ {PORT_W{inv}};
  endfunction

  function automatic logic fn_data_off(input logic [OFF_W-1:0] a);
    return (a == OFF_LO) || (a == OFF_HI) || (a == OFF_HI_DS);
  endfunction
endpackage

// File: rtl/hsp_timer.sv
module hsp_timer #(
  parameter int LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LEN);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cancel_i)      cnt_q <= '0;
    else if (start_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == ONE) && !start_i && !cancel_i;
endmodule

// File: rtl/hsp_edge.sv
module hsp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = !lvl_q && lvl_i;
  assign fall_o = lvl_q && !lvl_i;
endmodule

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
  import hsp_pkg::*;
#(
  parameter int DLY_CYC = 8,
  parameter int RST_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFF_W-1:0]  host_addr_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  output logic [PORT_W-1:0] dout_o,
  input  logic [PORT_W-1:0] din_i,
  output logic              strb_o,
  output logic              dir_o,
  output logic              prst_n_o,
  output logic [1:0]        aux_lo_o,
  input  logic              flag_rdy_i,
  input  logic [1:0]        stat_in_i,
  input  logic              attn_n_i,
  input  logic              health_i,
  input  logic              health_ok_lvl_i,
  input  logic              dout_inv_i,
  input  logic              dout_clr_en_i
);
  localparam int NBYTE = PORT_W / BYTE_W;

  // Named decode events
  logic wr_strb_w, ifc_rst_w, wr_aux_w, wr_ds_w, wr_data_w, rd_data_w, rd_start_w;
  logic dly_done_w, dly_busy_w, rst_busy_w, rst_done_w;
  logic flag_rise_w, flag_fall_w, strb_set_w;
  logic [NBYTE-1:0] wr_byte_w;
  logic [NBYTE-1:0] rd_byte_w;

  assign wr_strb_w  = host_wr_i && (host_addr_i == OFF_STRB);
  assign ifc_rst_w  = host_wr_i && (host_addr_i == OFF_RESET);
  assign wr_aux_w   = host_wr_i && (host_addr_i == OFF_AUX);
  assign wr_ds_w    = host_wr_i && (host_addr_i == OFF_HI_DS);
  assign wr_data_w  = host_wr_i && fn_data_off(host_addr_i);
  assign rd_data_w  = host_rd_i && !host_wr_i && fn_data_off(host_addr_i);
  assign rd_start_w = host_rd_i && !host_wr_i && (host_addr_i == OFF_HI_DS);
  assign wr_byte_w  = {host_wr_i && ((host_addr_i == OFF_HI) || (host_addr_i == OFF_HI_DS)),
                       host_wr_i && (host_addr_i == OFF_LO)};
  assign rd_byte_w  = {host_addr_i == OFF_HI, host_addr_i == OFF_LO};

  hsp_timer #(.LEN(DLY_CYC)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(wr_ds_w), .cancel_i(ifc_rst_w),
    .busy_o(dly_busy_w), .done_o(dly_done_w)
  );

  hsp_timer #(.LEN(RST_CYC)) u_prst (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ifc_rst_w), .cancel_i(1'b0),
    .busy_o(rst_busy_w), .done_o(rst_done_w)
  );

  hsp_edge u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(flag_rdy_i),
    .rise_o(flag_rise_w), .fall_o(flag_fall_w)
  );

  assign strb_set_w = wr_strb_w || rd_start_w || dly_done_w;
  assign prst_n_o   = !rst_busy_w;

  // Strobe: interface reset > set request > ready-to-busy clear
  logic strb_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          strb_q <= 1'b0;
    else if (ifc_rst_w)   strb_q <= 1'b0;
    else if (strb_set_w)  strb_q <= 1'b1;
    else if (flag_fall_w) strb_q <= 1'b0;
  end
  assign strb_o = strb_q;

  // Direction line
  logic dir_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dir_q <= 1'b1;
    else if (wr_data_w) dir_q <= 1'b0;
    else if (rd_data_w) dir_q <= 1'b1;
  end
  assign dir_o = dir_q;

  // Auxiliary drives
  logic [1:0] aux_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       aux_q <= '0;
    else if (wr_aux_w) aux_q <= host_wdata_i[1:0];
  end
  assign aux_lo_o = aux_q;

  // Byte lanes: output latch and input capture
  logic [PORT_W-1:0] dout_q, din_q;
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          dout_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (ifc_rst_w && dout_clr_en_i)  dout_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (wr_byte_w[b])                dout_q[b*BYTE_W +: BYTE_W] <= host_wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          din_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (flag_rise_w) din_q[b*BYTE_W +: BYTE_W] <= din_i[b*BYTE_W +: BYTE_W];
    end
  end
  assign dout_o = fn_drive(dout_q, dout_inv_i);

  // Read mux
  always_comb begin
    host_rdata_o = '0;
    unique case (1'b1)
      host_addr_i == OFF_STRB:  host_rdata_o = {7'b0, fn_ready(strb_q, flag_rdy_i)};
      host_addr_i == OFF_RESET: host_rdata_o = PORT_ID;
      host_addr_i == OFF_AUX:   host_rdata_o = fn_stat(stat_in_i, attn_n_i, health_i,
                                                       health_ok_lvl_i);
      rd_byte_w[0]:             host_rdata_o = din_q[BYTE_W-1:0];
      rd_byte_w[1]:             host_rdata_o = din_q[PORT_W-1:BYTE_W];
      default:                  host_rdata_o = '0;
    endcase
  end

  logic unused_w;
  assign unused_w = ^{dly_busy_w, rst_done_w, host_wdata_i[7:2]};
endmodule

// File: rtl/hsp_ctrl_chk.sv
module hsp_ctrl_chk
  import hsp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OFF_W-1:0]  host_addr_i,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic [BYTE_W-1:0] host_rdata_o,
  input logic              strb_o,
  input logic              dir_o,
  input logic              prst_n_o,
  input logic              ifc_rst_w,
  input logic              strb_set_w,
  input logic              flag_fall_w,
  input logic              dly_done_w
);
  p_rst_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifc_rst_w |=> (!prst_n_o && !strb_o));

  p_wr_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && fn_data_off(host_addr_i)) |=> !dir_o);

  p_delay_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_done_w && !ifc_rst_w) |=> strb_o);

  p_rd_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !host_wr_i && fn_data_off(host_addr_i)) |=> dir_o);

  p_rd_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !host_wr_i && host_addr_i == OFF_HI_DS) |=> strb_o);

  p_fall_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_fall_w && !strb_set_w && !ifc_rst_w) |=> !strb_o);

  p_ident_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && host_addr_i == OFF_RESET) |-> host_rdata_o == PORT_ID);
endmodule

bind hsp_ctrl hsp_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_addr_i(host_addr_i),
  .host_wr_i(host_wr_i), .host_rd_i(host_rd_i), .host_rdata_o(host_rdata_o),
  .strb_o(strb_o), .dir_o(dir_o), .prst_n_o(prst_n_o),
  .ifc_rst_w(ifc_rst_w), .strb_set_w(strb_set_w),
  .flag_fall_w(flag_fall_w), .dly_done_w(dly_done_w)
);

// File: tb/hsp_ctrl_tb.sv
module hsp_ctrl_tb;
  localparam int DLY  = 6;
  localparam int RSTC = 5;
  localparam int NV   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [15:0] dout, din = '0;
  logic strb, dir, prst_n;
  logic [1:0] aux;
  logic rdy = 1'b1;
  logic [1:0] stat = 2'b10;
  logic attn_n = 1'b0, health = 1'b1, ok_lvl = 1'b1, inv = 1'b0, clr_en = 1'b0;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hsp_ctrl #(.DLY_CYC(DLY), .RST_CYC(RSTC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_wr_i(wr),
    .host_rd_i(rd), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .dout_o(dout), .din_i(din), .strb_o(strb), .dir_o(dir),
    .prst_n_o(prst_n), .aux_lo_o(aux), .flag_rdy_i(rdy), .stat_in_i(stat),
    .attn_n_i(attn_n), .health_i(health), .health_ok_lvl_i(ok_lvl),
    .dout_inv_i(inv), .dout_clr_en_i(clr_en)
  );

  // {is_read, offset, write data, expected read data}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd7,  8'h01, 8'h00},
    {1'b1, 4'd7,  8'h00, 8'h0D},   // R9 status byte
    {1'b1, 4'd1,  8'h00, 8'h03},   // R8 identifier
    {1'b1, 4'd2,  8'h00, 8'h00},   // R8 unmapped
    {1'b0, 4'd8,  8'h3C, 8'h00},
    {1'b0, 4'd9,  8'hC3, 8'h00},
    {1'b1, 4'd0,  8'h00, 8'h01},   // R8 ready
    {1'b0, 4'd0,  8'h5A, 8'h00},   // R7 set strobe
    {1'b1, 4'd0,  8'h00, 8'h00}    // R8 not ready while strobe high
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(10 * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int cnt;
    idle(3);
    // R1 reset state
    chk(!strb && dir && prst_n && aux == 2'b00 && dout == 16'h0, "R1 reset state",
        {strb, dir, prst_n, aux}, 5'b01100);
    @(negedge clk); rst_n = 1'b1;
    idle(1);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][20]) begin
        do_rd(VEC[v][19:16], r);
        chk(r == VEC[v][7:0], $sformatf("R8/R9 vector %0d read", v), r, VEC[v][7:0]);
      end else begin
        do_wr(VEC[v][19:16], VEC[v][15:8]);
      end
    end
    chk(strb, "R7 strobe set by offset-0 write", strb, 1);

    // R9 auxiliary drives
    do_wr(4'd7, 8'h02);
    chk(aux == 2'b10, "R9 aux drive", aux, 2'b10);

    // R3 data and direction
    chk(dout == 16'hC33C && !dir, "R3 output latch / direction", {dout, dir}, {16'hC33C, 1'b0});

    // R2 interface reset without clear
    do_wr(4'd1, 8'h00);
    cnt = 0;
    while (!prst_n && cnt < 100) begin cnt++; @(negedge clk); end
    chk(cnt == RSTC, "R2 reset pulse length", cnt, RSTC);
    chk(!strb, "R2 strobe cleared", strb, 0);
    chk(dout == 16'hC33C, "R2 data kept when clear disabled", dout, 16'hC33C);
    clr_en = 1'b1;
    do_wr(4'd1, 8'hFF);
    chk(dout == 16'h0000, "R2 data cleared when enabled", dout, 0);
    idle(RSTC + 1);
    clr_en = 1'b0;

    // R3 polarity
    do_wr(4'd8, 8'h0F);
    inv = 1'b1; #1;
    chk(dout == 16'hFFF0, "R3 inverted polarity", dout, 16'hFFF0);
    inv = 1'b0;

    // R4 delayed strobe
    do_wr(4'd10, 8'hA1);
    chk(!dir && dout == 16'hA10F, "R4 high byte and direction", dout, 16'hA10F);
    idle(DLY - 1);
    chk(!strb, "R4 strobe not before delay", strb, 0);
    idle(1);
    chk(strb, "R4 strobe at delay", strb, 1);
    do_wr(4'd1, 8'h00); idle(RSTC + 1);

    // R4 restart
    do_wr(4'd10, 8'hA2);
    idle(3);
    do_wr(4'd10, 8'hA3);
    idle(DLY - 1);
    chk(!strb, "R4 restarted count not early", strb, 0);
    idle(1);
    chk(strb, "R4 restarted count on time", strb, 1);

    // R7 ready-to-busy clears strobe
    @(negedge clk); rdy = 1'b0;
    @(negedge clk);
    chk(!strb, "R7 fall clears strobe", strb, 0);
    do_rd(4'd0, r);
    chk(r == 8'h00, "R8 not ready while busy", r, 0);

    // R10 capture on busy-to-ready
    din = 16'hA55A;
    @(negedge clk); rdy = 1'b1;
    @(negedge clk); din = 16'h1234;
    do_rd(4'd8, r);
    chk(r == 8'h5A, "R10/R5 low input byte", r, 8'h5A);
    chk(dir, "R5 direction released", dir, 1);
    do_wr(4'd9, 8'h00);
    do_rd(4'd9, r);
    chk(r == 8'hA5 && dir, "R5 high input byte", r, 8'hA5);

    // R6 input start read
    do_wr(4'd8, 8'h00);
    do_rd(4'd10, r);
    chk(strb && dir, "R6 start read", {strb, dir}, 2'b11);

    // R2 cancels pending delayed strobe
    do_wr(4'd1, 8'h00);
    do_wr(4'd10, 8'h00);
    idle(2);
    do_wr(4'd1, 8'h00);
    idle(DLY + 2);
    chk(!strb, "R2 pending strobe cancelled", strb, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule